// File: doc/BRIEF.md
# Flash command interface controller

This block sits behind the host port of a parallel NOR-style nonvolatile memory. It decodes the command cycles the host writes and runs a small write state machine. A host write is one clock cycle with `wr_en` high. It carries an address and a 16-bit data word, and the low byte of the word is the command code. The controller keeps track of what a host read returns: array data, the status byte, identifier words or query bytes. It accepts two-cycle sequences for word program, block erase, lock-bit set or clear, and protection-register program.

Each accepted program, erase or protection operation sends a one-cycle request to a behavioural array model. Each accepted lock operation updates a bank of per-block lock bits. An operation holds the state machine busy for a number of cycles set on the `op_cycles` input. Failures are reported in a sticky status byte. A low `vpen_ok` input blocks every modifying operation. A lock bit set on a block stops program and erase on that block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data, `ready` is 1, the status byte is 80h and every lock bit is clear.
- R2: Writing FFh selects array reads and 70h selects status reads. 90h selects identifier reads, where offset 0 returns `ID_MAKER`, offset 1 returns `ID_DEVICE` and offset 2 returns the block's lock bit in bit 0. 98h selects query reads, where offsets 10h, 11h and 12h return 0051h, 0052h and 0059h and other offsets return 0. The offset is the address bits below the block index.
- R3: 40h or 10h, followed by a write of address and data, issues one request with op code 0 and that address and data. Reads then switch to the status byte.
- R4: 20h followed by D0h issues one request with op code 1, carrying the address of the second write. Reads switch to status.
- R5: 60h then 01h sets the lock bit of the addressed block. 60h then D0h clears all lock bits. Both make the controller busy and switch reads to status.
- R6: C0h followed by address and data issues one request with op code 2. This operation ignores lock bits.
- R7: The status byte holds ready in bit 7, the erase or clear-lock error in bit 5, the program or set-lock error in bit 4 and the voltage error in bit 3, with the other bits 0. Error bits stay set until 50h is written while the controller is ready.
- R8: With `vpen_ok` low, a program, protection or set-lock second cycle sets bits 3 and 4, and an erase or clear-lock second cycle sets bits 3 and 5. No operation starts.
- R9: While busy, only FFh, 70h, 90h and 98h take effect. Lock, program, erase, setup and clear-status writes are ignored.
- R10: An erase or lock second cycle with a code other than its confirm code sets bits 4 and 5, starts nothing and leaves reads in status mode.
- R11: A program to a locked block sets bit 4 and an erase of a locked block sets bit 5. Neither starts.
- R12: An operation keeps `ready` low for exactly `op_cycles` cycles, counted from the cycle after the accepting write. A value of 0 counts as 1.
- R13: The block index is address bits 21 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 22 | Host write address |
| wr_data | input | 16 | Host write data; low byte is the command code |
| rd_addr | input | 22 | Host read address |
| rd_data | output | 16 | Registered read data, one cycle after the address |
| vpen_ok | input | 1 | High when the program-enable supply is above lockout |
| op_cycles | input | 16 | Busy duration of the next operation |
| ready | output | 1 | State machine idle |
| arr_req | output | 1 | One-cycle operation request to the array model |
| arr_op | output | 2 | Request type: 0 program, 1 erase, 2 protection program |
| arr_addr | output | 22 | Request address |
| arr_wdata | output | 16 | Request data |
| arr_rdata | input | 16 | Array read data from the array model |

## Verification
The bench sends lock commands while an erase is still running, then checks through an identifier read that the lock bit did not change. A controller that accepts writes while busy would report the block as locked. A bad erase confirm code is sent as FFh, so a decoder that treats FFh as a read-array reset even in the middle of a sequence would return array data instead of status B0h. The bench programs both sides of a block boundary next to a locked block. An off-by-one slice of the block index would either reject the program to the unlocked block or accept the program to the locked one. Busy length is counted for a normal value and for zero, so an off-by-one counter or a zero-cycle operation shows up as a wrong count.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PROG,
    SEQ_ERASE,
    SEQ_LOCK,
    SEQ_PROT
  } seq_e;

  localparam logic [1:0] OP_PROG  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_PROT  = 2'd2;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_RD_IDENT = 8'h90;
  localparam logic [7:0] CMD_RD_QUERY = 8'h98;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_PROT     = 8'hC0;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SET = 8'h01;

  // error vector positions: [0] voltage, [1] program/set-lock, [2] erase/clear-lock
  localparam logic [2:0] ERR_VOLT = 3'b001;
  localparam logic [2:0] ERR_PGM  = 3'b010;
  localparam logic [2:0] ERR_ERS  = 3'b100;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          ready
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] load;

  always_comb load = (len == '0) ? CW'(1) : len;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= load;
    else if (cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int NBLK = 64,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic            clr_all,
  input  logic [BW-1:0]   wr_blk,
  input  logic [BW-1:0]   rd_blk,
  output logic            wr_hit,
  output logic            rd_hit,
  output logic [NBLK-1:0] locks
);
  for (genvar b = 0; b < NBLK; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all)                    locks[b] <= 1'b0;
      else if (set_en && wr_blk == BW'(b))   locks[b] <= 1'b1;
    end
  end

  assign wr_hit = locks[wr_blk];
  assign rd_hit = locks[rd_blk];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          vpen_ok,
  input  logic          ready,
  input  logic          lock_hit,
  output rd_mode_e      mode,
  output logic [2:0]    err,
  output logic          start,
  output logic          lock_set,
  output logic          lock_clr,
  output logic          arr_req,
  output logic [1:0]    arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  seq_e       seq, seq_n;
  rd_mode_e   mode_n;
  logic [2:0] err_n;
  logic       go_arr;
  logic [1:0] op_n;
  logic [7:0] cmd;

  assign cmd = wr_data[7:0];

  always_comb begin
    seq_n    = seq;
    mode_n   = mode;
    err_n    = err;
    start    = 1'b0;
    go_arr   = 1'b0;
    op_n     = OP_PROG;
    lock_set = 1'b0;
    lock_clr = 1'b0;
    if (wr_en) begin
      if (seq == SEQ_IDLE) begin
        case (cmd)
          CMD_RD_ARRAY: mode_n = MODE_ARRAY;
          CMD_RD_STAT:  mode_n = MODE_STATUS;
          CMD_RD_IDENT: mode_n = MODE_IDENT;
          CMD_RD_QUERY: mode_n = MODE_QUERY;
          CMD_CLR_STAT: if (ready) err_n = '0;
          CMD_PROG, CMD_PROG_ALT: if (ready) seq_n = SEQ_PROG;
          CMD_ERASE:    if (ready) seq_n = SEQ_ERASE;
          CMD_LOCK:     if (ready) seq_n = SEQ_LOCK;
          CMD_PROT:     if (ready) seq_n = SEQ_PROT;
          default: ;
        endcase
      end else begin
        seq_n  = SEQ_IDLE;
        mode_n = MODE_STATUS;
        case (seq)
          SEQ_PROG, SEQ_PROT: begin
            if (!vpen_ok)                         err_n = err | ERR_VOLT | ERR_PGM;
            else if (seq == SEQ_PROG && lock_hit) err_n = err | ERR_PGM;
            else begin
              start  = 1'b1;
              go_arr = 1'b1;
              op_n   = (seq == SEQ_PROG) ? OP_PROG : OP_PROT;
            end
          end
          SEQ_ERASE: begin
            if (cmd != CMD_CONFIRM) err_n = err | ERR_PGM | ERR_ERS;
            else if (!vpen_ok)      err_n = err | ERR_VOLT | ERR_ERS;
            else if (lock_hit)      err_n = err | ERR_ERS;
            else begin
              start  = 1'b1;
              go_arr = 1'b1;
              op_n   = OP_ERASE;
            end
          end
          SEQ_LOCK: begin
            if (cmd == CMD_LOCK_SET) begin
              if (!vpen_ok) err_n = err | ERR_VOLT | ERR_PGM;
              else begin start = 1'b1; lock_set = 1'b1; end
            end else if (cmd == CMD_CONFIRM) begin
              if (!vpen_ok) err_n = err | ERR_VOLT | ERR_ERS;
              else begin start = 1'b1; lock_clr = 1'b1; end
            end else begin
              err_n = err | ERR_PGM | ERR_ERS;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq       <= SEQ_IDLE;
      mode      <= MODE_ARRAY;
      err       <= '0;
      arr_req   <= 1'b0;
      arr_op    <= OP_PROG;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      seq     <= seq_n;
      mode    <= mode_n;
      err     <= err_n;
      arr_req <= go_arr;
      if (go_arr) begin
        arr_op    <= op_n;
        arr_addr  <= wr_addr;
        arr_wdata <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          AW        = 22,
  parameter int          DW        = 16,
  parameter int          NBLK      = 64,
  parameter int          CW        = 16,
  parameter logic [15:0] ID_MAKER  = 16'h0055,
  parameter logic [15:0] ID_DEVICE = 16'h2241
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          vpen_ok,
  input  logic [CW-1:0] op_cycles,
  output logic          ready,
  output logic          arr_req,
  output logic [1:0]    arr_op,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  input  logic [DW-1:0] arr_rdata
);
  localparam int BW   = $clog2(NBLK);
  localparam int OFFW = AW - BW;

  rd_mode_e        rd_mode;
  logic [2:0]      err_bits;
  logic            op_start, lk_set, lk_clr, lk_wr_hit, lk_rd_hit;
  logic [NBLK-1:0] lock_vec;
  logic [7:0]      status;
  logic [OFFW-1:0] rd_off;

  flash_cmd_decode #(.AW(AW), .DW(DW)) i_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpen_ok(vpen_ok), .ready(ready), .lock_hit(lk_wr_hit), .mode(rd_mode),
    .err(err_bits), .start(op_start), .lock_set(lk_set), .lock_clr(lk_clr),
    .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  flash_lock_bits #(.NBLK(NBLK)) i_lock (
    .clk(clk), .rst(rst), .set_en(lk_set), .clr_all(lk_clr),
    .wr_blk(wr_addr[AW-1 -: BW]), .rd_blk(rd_addr[AW-1 -: BW]),
    .wr_hit(lk_wr_hit), .rd_hit(lk_rd_hit), .locks(lock_vec)
  );

  flash_busy_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst(rst), .start(op_start), .len(op_cycles), .ready(ready)
  );

  assign status = {ready, 1'b0, err_bits[2], err_bits[1], err_bits[0], 3'b000};
  assign rd_off = rd_addr[OFFW-1:0];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_mode)
        MODE_ARRAY:  rd_data <= arr_rdata;
        MODE_STATUS: rd_data <= DW'(status);
        MODE_IDENT: begin
          if (rd_off == OFFW'(0))      rd_data <= DW'(ID_MAKER);
          else if (rd_off == OFFW'(1)) rd_data <= DW'(ID_DEVICE);
          else if (rd_off == OFFW'(2)) rd_data <= DW'(lk_rd_hit);
          else                         rd_data <= '0;
        end
        default: begin
          if (rd_off == OFFW'(16'h10))      rd_data <= DW'(16'h0051);
          else if (rd_off == OFFW'(16'h11)) rd_data <= DW'(16'h0052);
          else if (rd_off == OFFW'(16'h12)) rd_data <= DW'(16'h0059);
          else                              rd_data <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int NBLK = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            vpen_ok,
  input logic            ready,
  input logic            arr_req,
  input logic [1:0]      rd_mode,
  input logic [2:0]      err_bits,
  input logic [NBLK-1:0] lock_vec
);
  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (rst) arr_req |-> !ready);
  // R3
  req_mode_chk: assert property (@(posedge clk) disable iff (rst) arr_req |-> rd_mode == 2'd1);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) arr_req |=> !arr_req);
  // R8
  req_vpen_chk: assert property (@(posedge clk) disable iff (rst) arr_req |-> $past(vpen_ok));
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(err_bits));
  // R9
  lock_busy_chk: assert property (@(posedge clk) disable iff (rst) !ready |=> $stable(lock_vec));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.NBLK(NBLK)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .vpen_ok(vpen_ok), .ready(ready),
  .arr_req(arr_req), .rd_mode(rd_mode), .err_bits(err_bits), .lock_vec(lock_vec)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [21:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [21:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        vpen_ok = 1;
  logic [15:0] op_cycles = 16'd5;
  logic        ready, arr_req;
  logic [1:0]  arr_op;
  logic [21:0] arr_addr;
  logic [15:0] arr_wdata;
  logic [15:0] arr_rdata = 16'hA5A5;

  int n_chk = 0;
  int n_fail = 0;
  logic [39:0] exp_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vpen_ok(vpen_ok), .op_cycles(op_cycles),
    .ready(ready), .arr_req(arr_req), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [21:0] a, input logic [15:0] d);
    exp_q.push_back({op, a, d});
  endtask

  // monitor: pops the scoreboard as requests appear
  always @(negedge clk) begin
    if (!rst && arr_req) begin
      if (exp_q.size() == 0) check("R3/R4/R6 unexpected request", {arr_op, arr_addr, arr_wdata}, '0);
      else check("R3/R4/R6 request contents", {arr_op, arr_addr, arr_wdata}, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [15:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_ready(output int c);
    c = 0;
    while (!ready && c < 2000) begin c++; @(negedge clk); end
  endtask

  task automatic clr_stat();
    wr(22'h0, 16'h0050);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] d;
    int c;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 ready after reset", 40'(ready), 40'd1);
    rd(22'h0, d); check("R1 array read after reset", 40'(d), 40'hA5A5);
    wr(22'h0, 16'h0090);
    rd(22'h050002, d); check("R1 lock clear after reset", 40'(d), 40'h0);
    wr(22'h0, 16'h0070);
    rd(22'h0, d); check("R1 status after reset", 40'(d), 40'h80);
    // R2 read modes
    wr(22'h0, 16'h0090);
    rd(22'h0, d); check("R2 maker id", 40'(d), 40'h0055);
    rd(22'h1, d); check("R2 device id", 40'(d), 40'h2241);
    wr(22'h0, 16'h0098);
    rd(22'h10, d); check("R2 query 10h", 40'(d), 40'h0051);
    rd(22'h12, d); check("R2 query 12h", 40'(d), 40'h0059);
    wr(22'h0, 16'h00FF);
    rd(22'h0, d); check("R2 back to array", 40'(d), 40'hA5A5);
    // R3 program and R12 busy length
    push(2'd0, 22'h012345, 16'hBEEF);
    wr(22'h0, 16'h0040);
    wr(22'h012345, 16'hBEEF);
    wait_ready(c); check("R12 busy length 5", 40'(c), 40'd5);
    rd(22'h0, d); check("R3 auto status after program", 40'(d), 40'h80);
    // R4 erase with R9 lock commands while busy
    op_cycles = 16'd20;
    push(2'd1, 22'h030000, 16'h00D0);
    wr(22'h0, 16'h0020);
    wr(22'h030000, 16'h00D0);
    wr(22'h030000, 16'h0060);
    wr(22'h030000, 16'h0001);
    wait_ready(c);
    op_cycles = 16'd5;
    wr(22'h0, 16'h0090);
    rd(22'h030002, d); check("R9 lock ignored while busy", 40'(d), 40'h0);
    // R5 set lock on block 7, R13 block index
    wr(22'h070000, 16'h0060);
    wr(22'h070000, 16'h0001);
    wait_ready(c);
    wr(22'h0, 16'h0090);
    rd(22'h070002, d); check("R5 R13 lock set block 7", 40'(d), 40'h1);
    rd(22'h060002, d); check("R13 neighbour block unlocked", 40'(d), 40'h0);
    // R11 program to locked block
    wr(22'h0, 16'h0040);
    wr(22'h07ABCD, 16'h1111);
    rd(22'h0, d); check("R11 program locked block", 40'(d), 40'h90);
    clr_stat();
    rd(22'h0, d); check("R7 clear status", 40'(d), 40'h80);
    // R13 last word of block 6 is not locked
    push(2'd0, 22'h06FFFF, 16'h2222);
    wr(22'h0, 16'h0040);
    wr(22'h06FFFF, 16'h2222);
    wait_ready(c);
    // R11 erase of locked block
    wr(22'h0, 16'h0020);
    wr(22'h070000, 16'h00D0);
    rd(22'h0, d); check("R11 erase locked block", 40'(d), 40'hA0);
    clr_stat();
    // R6 protection program ignores locks
    push(2'd2, 22'h070081, 16'h1234);
    wr(22'h0, 16'h00C0);
    wr(22'h070081, 16'h1234);
    wait_ready(c);
    rd(22'h0, d); check("R6 protection program status", 40'(d), 40'h80);
    // R5 clear all
    wr(22'h0, 16'h0060);
    wr(22'h0, 16'h00D0);
    wait_ready(c);
    wr(22'h0, 16'h0090);
    rd(22'h070002, d); check("R5 locks cleared", 40'(d), 40'h0);
    // R8 vpen lockout
    vpen_ok = 0;
    wr(22'h0, 16'h0040);
    wr(22'h001000, 16'h3333);
    rd(22'h0, d); check("R8 program under lockout", 40'(d), 40'h98);
    clr_stat();
    wr(22'h0, 16'h0020);
    wr(22'h020000, 16'h00D0);
    rd(22'h0, d); check("R8 erase under lockout", 40'(d), 40'hA8);
    clr_stat();
    vpen_ok = 1;
    // R10 bad confirm, FFh as second cycle
    wr(22'h0, 16'h0020);
    wr(22'h020000, 16'h00FF);
    rd(22'h0, d); check("R10 bad confirm status mode", 40'(d), 40'hB0);
    clr_stat();
    // R12 zero length counts as one
    op_cycles = 16'd0;
    push(2'd0, 22'h000010, 16'h4444);
    wr(22'h0, 16'h0010);
    wr(22'h000010, 16'h4444);
    wait_ready(c); check("R12 zero length busy", 40'(c), 40'd1);
    repeat (3) @(negedge clk);
    check("R3 all requests seen", 40'(exp_q.size()), 40'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule